// File: doc/BRIEF.md
# Move-Only Transport-Triggered Processor Core

This core runs programs made of one kind of instruction: copy a word from one bus address to another. It has no opcode field and no decoder. An instruction is two consecutive 16-bit words in memory. The first word is the source address and the second is the destination address. Arithmetic, I/O and branching all live in memory-mapped devices outside the core. The core only carries words between those devices over one shared bus that holds both code and data.

Every instruction takes four clock cycles, in a fixed order:

1. Fetch the source word.
2. Fetch the destination word.
3. Read the operand from the source address.
4. Write the operand to the destination address.

The instruction counter is mapped at the all-ones address and is handled inside the core. Moving a word to that address is a jump. Moving a word from that address reads the counter. Neither access appears as a strobe on the external bus, so no external device can answer at that address. Outside the core, the system places code at 0x0000–0x7FFF and RAM at 0x8000–0xBFFF.

Top module: `xfer_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the core presents the first fetch phase: `busAddr` = 0x0000, `busRd` = 1, `busWr` = 0.
- R2: The four phases repeat in the order fetch-source, fetch-destination, operand read, operand write. In the read phase `busAddr` is the fetched source word. In the write phase `busAddr` is the fetched destination word and `busWdata` is the word captured in the read phase, unchanged.
- R3: The instruction counter advances by one after each of the two fetch phases and holds through the read and write phases. Both fetch phases put the counter on `busAddr`.
- R4: When the destination word is 0xFFFF, the write phase loads the operand into the instruction counter. The next fetch uses that loaded value, and `busWr` stays low during that phase.
- R5: When the source word is 0xFFFF, the operand is the instruction counter's value at the read phase, which is the address of the following instruction. `busRd` stays low during that phase.
- R6: `busRd` and `busWr` are never high together. `busWr` is high only in the write phase and `busRd` only in the fetch and read phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | output | 16 | Shared bus address |
| busRd | output | 1 | Read strobe; the addressed device returns data on busRdata in the same cycle |
| busRdata | input | 16 | Read data from the addressed device |
| busWr | output | 1 | Write strobe; the addressed device stores busWdata at the clock edge |
| busWdata | output | 16 | Write data |

## Verification
The assertions assume the external memory answers a read within the same cycle. They also assume `busRdata` is settled before the clock edge that ends the phase, so the word the core latches is the word on the bus. The bench meets this with a combinational memory model that decodes code, RAM and an unmapped filler region exclusively. Writes to the code region are dropped. The stimulus program touches the counter address both as source and as destination, and it includes a jump that skips a move whose result would otherwise be visible in RAM.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    PH_FSRC  = 2'd0,
    PH_FDST  = 2'd1,
    PH_READ  = 2'd2,
    PH_WRITE = 2'd3
  } phase_t;

  typedef struct packed {
    logic fetchSrc;
    logic fetchDst;
    logic readOp;
    logic writeOp;
  } strobe_t;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output strobe_t ctl
);

  phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FSRC;
    else begin
      unique case (phase)
        PH_FSRC:  phase <= PH_FDST;
        PH_FDST:  phase <= PH_READ;
        PH_READ:  phase <= PH_WRITE;
        default:  phase <= PH_FSRC;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    unique case (phase)
      PH_FSRC:  ctl.fetchSrc = 1'b1;
      PH_FDST:  ctl.fetchDst = 1'b1;
      PH_READ:  ctl.readOp   = 1'b1;
      default:  ctl.writeOp  = 1'b1;
    endcase
  end

endmodule

// File: rtl/xfer_dpath.sv
module xfer_dpath
  import xfer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  strobe_t      ctl,
  input  logic [W-1:0] busRdata,
  output logic [W-1:0] busAddr,
  output logic         busRd,
  output logic         busWr,
  output logic [W-1:0] busWdata,
  output logic [W-1:0] pcNow,
  output logic [W-1:0] srcNow,
  output logic [W-1:0] dstNow,
  output logic [W-1:0] dataNow
);

  localparam logic [W-1:0] PC_ADDR = {W{1'b1}};
  localparam logic [W-1:0] ONE     = W'(1);

  logic [W-1:0] pcReg, srcReg, dstReg, dataReg;
  logic         srcIsPc, dstIsPc;

  assign srcIsPc = (srcReg == PC_ADDR);
  assign dstIsPc = (dstReg == PC_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg   <= '0;
      srcReg  <= '0;
      dstReg  <= '0;
      dataReg <= '0;
    end else begin
      if (ctl.fetchSrc) begin
        srcReg <= busRdata;
        pcReg  <= pcReg + ONE;
      end
      if (ctl.fetchDst) begin
        dstReg <= busRdata;
        pcReg  <= pcReg + ONE;
      end
      if (ctl.readOp)
        dataReg <= srcIsPc ? pcReg : busRdata;
      if (ctl.writeOp && dstIsPc)
        pcReg <= dataReg;
    end
  end

  always_comb begin
    busAddr = pcReg;
    if (ctl.readOp)  busAddr = srcReg;
    if (ctl.writeOp) busAddr = dstReg;
  end

  assign busRd    = ctl.fetchSrc | ctl.fetchDst | (ctl.readOp & ~srcIsPc);
  assign busWr    = ctl.writeOp & ~dstIsPc;
  assign busWdata = dataReg;

  assign pcNow   = pcReg;
  assign srcNow  = srcReg;
  assign dstNow  = dstReg;
  assign dataNow = dataReg;

endmodule

// File: rtl/xfer_core.sv
module xfer_core
  import xfer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] busAddr,
  output logic         busRd,
  input  logic [W-1:0] busRdata,
  output logic         busWr,
  output logic [W-1:0] busWdata
);

  strobe_t      ctl;
  logic [W-1:0] pcNow, srcNow, dstNow, dataNow;

  xfer_ctrl ctrl_i (
    .clk (clk),
    .rst (rst),
    .ctl (ctl)
  );

  xfer_dpath #(.W(W)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .busWdata (busWdata),
    .pcNow    (pcNow),
    .srcNow   (srcNow),
    .dstNow   (dstNow),
    .dataNow  (dataNow)
  );

endmodule

// File: rtl/xfer_core_chk.sv
module xfer_core_chk
  import xfer_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         busRd,
  input logic         busWr,
  input strobe_t      ctl,
  input logic [W-1:0] pcNow,
  input logic [W-1:0] srcNow,
  input logic [W-1:0] dstNow,
  input logic [W-1:0] dataNow
);

  localparam logic [W-1:0] PC_ADDR = {W{1'b1}};

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(ctl) == 1);

  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.writeOp |=> ctl.fetchSrc);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busRd && busWr));

  // R6
  wr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    busWr |-> ctl.writeOp);

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.fetchSrc || ctl.fetchDst) |=> pcNow == $past(pcNow) + W'(1));

  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.readOp |=> $stable(pcNow));

  // R4
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.writeOp && dstNow == PC_ADDR) |=> pcNow == $past(dataNow));

  // R4
  pc_write_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.writeOp && dstNow == PC_ADDR) |-> !busWr);

  // R5
  pc_read_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.readOp && srcNow == PC_ADDR) |-> !busRd);

endmodule

bind xfer_core xfer_core_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .busRd   (busRd),
  .busWr   (busWr),
  .ctl     (ctl),
  .pcNow   (pcNow),
  .srcNow  (srcNow),
  .dstNow  (dstNow),
  .dataNow (dataNow)
);

// File: tb/xfer_core_tb_top.sv
module xfer_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] busAddr, busRdata, busWdata;
  logic        busRd, busWr;

  int compared = 0;
  int mismatched = 0;

  logic [15:0] rom [256];
  logic [15:0] ram [256];

  always #2 clk = ~clk;

  xfer_core dut_i (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busRdata (busRdata),
    .busWr    (busWr),
    .busWdata (busWdata)
  );

  function automatic logic [15:0] memRead(input logic [15:0] a);
    if (a[15:8] == 8'h00)      return rom[a[7:0]];
    else if (a[15:8] == 8'h80) return ram[a[7:0]];
    else                       return a ^ 16'hA5A5;
  endfunction

  always_comb busRdata = memRead(busAddr);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) ram[i] <= '0;
    end else if (busWr && busAddr[15:8] == 8'h80) begin
      ram[busAddr[7:0]] <= busWdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int          mPhase;
    logic [15:0] mPc, mSrc, mDst, mData, eAddr;
    logic        eRd, eWr;
    string       tag;

    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    rom[8'h00] = 16'h0040; rom[8'h01] = 16'h8000;   // const -> ram0
    rom[8'h02] = 16'h8000; rom[8'h03] = 16'h8001;   // ram0 -> ram1
    rom[8'h04] = 16'hFFFF; rom[8'h05] = 16'h8002;   // counter -> ram2
    rom[8'h06] = 16'h0041; rom[8'h07] = 16'hFFFF;   // jump 0x20
    rom[8'h08] = 16'h0043; rom[8'h09] = 16'h8004;   // skipped
    rom[8'h20] = 16'h8001; rom[8'h21] = 16'h8003;   // ram1 -> ram3
    rom[8'h22] = 16'h0042; rom[8'h23] = 16'hFFFF;   // self loop
    rom[8'h40] = 16'h1234;
    rom[8'h41] = 16'h0020;
    rom[8'h42] = 16'h0022;
    rom[8'h43] = 16'h0077;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs while reset is held
    chk(busAddr == 16'h0000, "R1 reset addr", busAddr, 16'h0000);
    chk(busRd == 1'b1 && busWr == 1'b0, "R1 reset strobes",
        {14'd0, busRd, busWr}, 16'h0002);
    rst = 1'b0;

    mPhase = 0; mPc = '0; mSrc = '0; mDst = '0; mData = '0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      eAddr = mPc; eRd = 1'b1; eWr = 1'b0; tag = "R3 fetch";
      if (cyc == 0) tag = "R1 first fetch";
      if (mPhase == 2) begin
        eAddr = mSrc; eRd = (mSrc != 16'hFFFF); eWr = 1'b0;
        tag = (mSrc == 16'hFFFF) ? "R5 counter read" : "R2 operand read";
      end else if (mPhase == 3) begin
        eAddr = mDst; eRd = 1'b0; eWr = (mDst != 16'hFFFF);
        tag = (mDst == 16'hFFFF) ? "R4 counter load" : "R2 operand write";
      end
      chk(busAddr == eAddr, {tag, " addr"}, busAddr, eAddr);
      // R6 strobe levels
      chk(busRd == eRd && busWr == eWr, {tag, " R6 strobes"},
          {14'd0, busRd, busWr}, {14'd0, eRd, eWr});
      if (mPhase == 3 && eWr)
        chk(busWdata == mData, "R2 write data", busWdata, mData);

      unique case (mPhase)
        0: begin mSrc = memRead(mPc); mPc = mPc + 16'd1; end
        1: begin mDst = memRead(mPc); mPc = mPc + 16'd1; end
        2: mData = (mSrc == 16'hFFFF) ? mPc : memRead(mSrc);
        default: if (mDst == 16'hFFFF) mPc = mData;
      endcase
      mPhase = (mPhase + 1) % 4;
      @(negedge clk);
    end

    chk(ram[0] == 16'h1234, "R2 ram0", ram[0], 16'h1234);
    chk(ram[1] == 16'h1234, "R2 ram1", ram[1], 16'h1234);
    chk(ram[2] == 16'h0006, "R5 ram2", ram[2], 16'h0006);
    chk(ram[3] == 16'h1234, "R4 ram3 after jump", ram[3], 16'h1234);
    chk(ram[4] == 16'h0000, "R4 skipped move", ram[4], 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule